// File: doc/BRIEF.md
# Microprogrammed Complex Butterfly Unit

This block computes one radix-2 decimation-in-time FFT butterfly on complex fixed-point operands. Given inputs A, B and a twiddle factor W, it returns the sum output A + B·W and the difference output A − B·W. Every real and imaginary part is a 16-bit signed Q1.15 value.

A small shared datapath does the work: one multiplier, one accumulating adder/subtractor, one rounder and one saturating write-back adder that drives a single result bus. A micro-program counter steps through a short control store. Each microword directly carries the register enables, the operand selects and the write-back destination, and it may also carry a jump. One conditional jump tests a datapath status flag, the pass flag, so the same five microwords run twice: once for the real half and once for the imaginary half.

The host starts an operation with a one-cycle start pulse, which also captures the operands. It then waits for a one-cycle done pulse. The results stay on the output ports until the next start.

Top module: `bfly_butterfly`

## Requirements
- R1: The outputs satisfy y0 = A + B·W and y1 = A − B·W. Here B·W = (Br·Wr − Bi·Wi) + j(Br·Wi + Bi·Wr), and every real and imaginary part is a 16-bit two's-complement Q1.15 value.
- R2: Each part of B·W is formed exactly at full precision and then rounded once to the Q1.15 LSB. Before saturation, the error of each output part is at most half an LSB.
- R3: A product part whose discarded 15 bits equal exactly one half LSB rounds to the neighbour that has an even LSB. For example, 1.5 LSB becomes 2, −1.5 LSB becomes −2 and 0.5 LSB becomes 0, so the rounding carries no average bias.
- R4: A sum or difference above 32767 outputs 32767, and one below −32768 outputs −32768.
- R5: The operands are captured on the clock edge that samples start high. Done is high for exactly one cycle: the cycle after the 11th rising edge, counting the edge that sampled start. The results are valid in that cycle.
- R6: Once an operation has finished, the outputs do not change until the next start, even if the operand inputs change.
- R7: A start that arrives during an operation abandons it. The unit takes the new operands, and it delivers done and the new results 11 edges after that start.
- R8: A synchronous active-low reset clears all four outputs to zero and done to low, and it abandons any operation in progress, so no done pulse follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; operands are captured on this edge |
| a_re | input | 16 | Real part of A, Q1.15 |
| a_im | input | 16 | Imaginary part of A, Q1.15 |
| b_re | input | 16 | Real part of B, Q1.15 |
| b_im | input | 16 | Imaginary part of B, Q1.15 |
| w_re | input | 16 | Real part of twiddle W, Q1.15 |
| w_im | input | 16 | Imaginary part of twiddle W, Q1.15 |
| done | output | 1 | One-cycle pulse when the results are ready |
| y0_re | output | 16 | Real part of A + B·W |
| y0_im | output | 16 | Imaginary part of A + B·W |
| y1_re | output | 16 | Real part of A − B·W |
| y1_im | output | 16 | Imaginary part of A − B·W |

## Verification
The assertions check four things on every cycle:
- every rounding step lands within half an LSB of the full-precision accumulator;
- an exact tie always yields an even result;
- start always sends the sequencer to the entry microword, and done never lasts two cycles;
- the outputs do not move while the sequencer idles.

Only the bench scenarios can show the rest:
- that the arithmetic of the whole butterfly is right, checked against a wide-integer reference;
- the exact 11-edge latency;
- saturation at both rails;
- that a restart really picks up the new operands;
- that a reset mid-operation suppresses done.

// File: rtl/bfly_pkg.sv
// Package: shared constants and the microword layout for the butterfly unit.
// Assumes a control store of at most 2**UPC_W words.
package bfly_pkg;
    localparam int UPC_W = 3;

    localparam logic [UPC_W-1:0] UA_IDLE  = UPC_W'(0);
    localparam logic [UPC_W-1:0] UA_ENTRY = UPC_W'(1);

    // Accumulator operation requested by a microword.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_MAC  = 2'd2
    } acc_op_e;

    // Jump kind: none, unconditional, or taken while the first pass runs.
    typedef enum logic [1:0] {
        JMP_NONE   = 2'd0,
        JMP_ALWAYS = 2'd1,
        JMP_PASS0  = 2'd2
    } jmp_e;

    // One horizontal microword: every field drives the datapath directly.
    typedef struct packed {
        acc_op_e          acc_op;    // multiplier into accumulator: hold, load, add/sub
        logic             b_imag;    // multiplier left operand: 0 = B real, 1 = B imag
        logic             w_cross;   // multiplier right operand: W part equal to / opposite of pass
        logic             sub_pass0; // accumulate with subtraction during the real pass
        logic             rnd_en;    // load the rounded product register
        logic             wb_en;     // write the result bus into an output register
        logic             wb_diff;   // 0 = sum output, 1 = difference output
        logic             pass_tgl;  // flip the real/imag pass flag
        jmp_e             jmp;
        logic [UPC_W-1:0] target;
        logic             done;
    } uword_t;
endpackage

// File: rtl/bfly_ucode_rom.sv
// Control store: maps a micro-address to its microword.
// The program runs one half of the butterfly per pass. Words 1..5 execute for the
// real half, jump back once, execute for the imaginary half, then word 6 signals done.
module bfly_ucode_rom
    import bfly_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    // Decode the address into control fields.
    always_comb begin
        word        = '0;
        word.acc_op = ACC_HOLD;
        word.jmp    = JMP_NONE;
        case (addr)
            UPC_W'(0): begin                 // idle: park here
                word.jmp    = JMP_ALWAYS;
                word.target = UA_IDLE;
            end
            UPC_W'(1): begin                 // acc = Br * W[same part]
                word.acc_op = ACC_LOAD;
            end
            UPC_W'(2): begin                 // acc -/+= Bi * W[other part]
                word.acc_op    = ACC_MAC;
                word.b_imag    = 1'b1;
                word.w_cross   = 1'b1;
                word.sub_pass0 = 1'b1;
            end
            UPC_W'(3): begin                 // round acc to the operand LSB
                word.rnd_en = 1'b1;
            end
            UPC_W'(4): begin                 // sum output <= sat(A + t)
                word.wb_en = 1'b1;
            end
            UPC_W'(5): begin                 // diff output <= sat(A - t), next pass
                word.wb_en    = 1'b1;
                word.wb_diff  = 1'b1;
                word.pass_tgl = 1'b1;
                word.jmp      = JMP_PASS0;
                word.target   = UA_ENTRY;
            end
            UPC_W'(6): begin                 // final word: report completion
                word.done   = 1'b1;
                word.jmp    = JMP_ALWAYS;
                word.target = UA_IDLE;
            end
            default: begin
                word.jmp    = JMP_ALWAYS;
                word.target = UA_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/bfly_useq.sv
// Micro-program counter. Start forces the entry address. Otherwise a taken jump
// loads the microword target and any other word advances by one.
// Assumes the status flag is valid in the cycle its microword executes.
module bfly_useq
    import bfly_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  uword_t           word,
    input  logic             pass0,
    output logic [UPC_W-1:0] upc
);
    logic taken;

    // Evaluate the jump condition of the current microword.
    always_comb begin
        taken = (word.jmp == JMP_ALWAYS) || ((word.jmp == JMP_PASS0) && pass0);
    end

    // Advance the micro-program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      upc <= UA_IDLE;
        else if (start)  upc <= UA_ENTRY;
        else if (taken)  upc <= word.target;
        else             upc <= upc + 1'b1;
    end

    // R5 and R7: any start, busy or not, restarts the program at the entry word.
    p_start_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (upc == UA_ENTRY));
endmodule

// File: rtl/bfly_round_rne.sv
// Combinational rounder: drops DROP fraction bits from a signed value and rounds
// to nearest, with ties to the even neighbour.
// Assumes the input is not within one LSB of the positive rail (so the +1 cannot wrap).
module bfly_round_rne #(
    parameter int IN_W = 34,
    parameter int DROP = 15
) (
    input  logic signed [IN_W-1:0]      din,
    output logic signed [IN_W-DROP-1:0] dout
);
    localparam int OUT_W = IN_W - DROP;
    localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

    logic signed [OUT_W-1:0] trunc;
    logic [DROP-1:0]         frac;
    logic                    up;

    // Floor by truncation, then decide the increment from the dropped bits.
    always_comb begin
        trunc = din[IN_W-1:DROP];
        frac  = din[DROP-1:0];
        up    = (frac > HALF) || ((frac == HALF) && trunc[0]);
        dout  = trunc + $signed({{(OUT_W-1){1'b0}}, up});
    end
endmodule

// File: rtl/bfly_datapath.sv
// Shared butterfly datapath: operand registers, one multiplier, one accumulator,
// one rounder and a saturating write-back adder driving a single result bus.
// Assumes the control store issues the load, accumulate, round and write-back steps
// in that order within each pass.
module bfly_datapath
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  uword_t               word,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic                 pass0,
    output logic signed [DW-1:0] y0_re,
    output logic signed [DW-1:0] y0_im,
    output logic signed [DW-1:0] y1_re,
    output logic signed [DW-1:0] y1_im
);
    localparam int PW    = 2 * DW;
    localparam int ACC_W = PW + 2;
    localparam int T_W   = ACC_W - FW;
    localparam int S_W   = T_W + 1;
    localparam logic signed [S_W-1:0]   SMAX = S_W'((1 <<< (DW-1)) - 1);
    localparam logic signed [S_W-1:0]   SMIN = -SMAX - S_W'(1);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 <<< (FW-1));

    logic signed [DW-1:0]    opa [2];
    logic signed [DW-1:0]    opb [2];
    logic signed [DW-1:0]    opw [2];
    logic                    pass;
    logic signed [DW-1:0]    mul_x, mul_y;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext, acc;
    logic signed [T_W-1:0]   t_next, t_reg;
    logic signed [S_W-1:0]   a_ext, t_ext, sum;
    logic signed [DW-1:0]    res_bus;
    logic signed [DW-1:0]    y0_q [2];
    logic signed [DW-1:0]    y1_q [2];

    // Capture the operands on start; index 0 is real, 1 is imaginary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                opa[k] <= '0;
                opb[k] <= '0;
                opw[k] <= '0;
            end
        end else if (start) begin
            opa[0] <= a_re;  opa[1] <= a_im;
            opb[0] <= b_re;  opb[1] <= b_im;
            opw[0] <= w_re;  opw[1] <= w_im;
        end
    end

    // Pass flag: 0 while computing the real half, 1 for the imaginary half.
    always_ff @(posedge clk) begin
        if (!rst_n || start)    pass <= 1'b0;
        else if (word.pass_tgl) pass <= ~pass;
    end

    assign pass0 = ~pass;

    // Select multiplier operands and form the full-precision product.
    always_comb begin
        mul_x    = word.b_imag ? opb[1] : opb[0];
        mul_y    = opw[word.w_cross ^ pass];
        prod     = mul_x * mul_y;
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

    // Accumulate the two partial products of one part of B*W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            case (word.acc_op)
                ACC_LOAD: acc <= prod_ext;
                ACC_MAC:  acc <= (word.sub_pass0 && !pass) ? acc - prod_ext : acc + prod_ext;
                default:  acc <= acc;
            endcase
        end
    end

    bfly_round_rne #(.IN_W(ACC_W), .DROP(FW)) u_round (
        .din  (acc),
        .dout (t_next)
    );

    // Hold the rounded product part for the two write-back steps.
    always_ff @(posedge clk) begin
        if (!rst_n)           t_reg <= '0;
        else if (word.rnd_en) t_reg <= t_next;
    end

    // Write-back adder with saturation onto the shared result bus.
    always_comb begin
        a_ext = {{(S_W-DW){opa[pass][DW-1]}}, opa[pass]};
        t_ext = {t_reg[T_W-1], t_reg};
        sum   = word.wb_diff ? a_ext - t_ext : a_ext + t_ext;
        if (sum > SMAX)      res_bus = {1'b0, {(DW-1){1'b1}}};
        else if (sum < SMIN) res_bus = {1'b1, {(DW-1){1'b0}}};
        else                 res_bus = sum[DW-1:0];
    end

    // Output registers: the bus lands in the part selected by pass and wb_diff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                y0_q[k] <= '0;
                y1_q[k] <= '0;
            end
        end else if (word.wb_en) begin
            if (word.wb_diff) y1_q[pass] <= res_bus;
            else              y0_q[pass] <= res_bus;
        end
    end

    assign y0_re = y0_q[0];
    assign y0_im = y0_q[1];
    assign y1_re = y1_q[0];
    assign y1_im = y1_q[1];

    logic signed [ACC_W-1:0] t_scaled;
    assign t_scaled = {t_reg, {FW{1'b0}}};

    // R2: the rounded value is within half an LSB of the accumulator it came from.
    p_round_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word.rnd_en |=> ((t_scaled - $past(acc)) <= HALF) && ((t_scaled - $past(acc)) >= -HALF));

    // R3: an exact tie always produces an even result.
    p_tie_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word.rnd_en && (acc[FW-1:0] == HALF[FW-1:0])) |=> !t_reg[0]);
endmodule

// File: rtl/bfly_butterfly.sv
// Top of the microprogrammed complex butterfly: control store, sequencer and
// shared datapath. Computes y0 = A + B*W and y1 = A - B*W in Q1.15.
// Assumes start is a single-cycle pulse; done pulses in the final microword.
module bfly_butterfly
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic                 done,
    output logic signed [DW-1:0] y0_re,
    output logic signed [DW-1:0] y0_im,
    output logic signed [DW-1:0] y1_re,
    output logic signed [DW-1:0] y1_im
);
    logic [UPC_W-1:0] upc;
    uword_t           word;
    logic             pass0;

    bfly_ucode_rom u_rom (
        .addr (upc),
        .word (word)
    );

    bfly_useq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .pass0 (pass0),
        .upc   (upc)
    );

    bfly_datapath #(.DW(DW), .FW(FW)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .a_re  (a_re),
        .a_im  (a_im),
        .b_re  (b_re),
        .b_im  (b_im),
        .w_re  (w_re),
        .w_im  (w_im),
        .pass0 (pass0),
        .y0_re (y0_re),
        .y0_im (y0_im),
        .y1_re (y1_re),
        .y1_im (y1_im)
    );

    // Completion comes straight from the executing microword.
    assign done = word.done;

    // R5: done lasts exactly one cycle.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: while the sequencer idles and no start arrives, the results stay put.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((upc == UA_IDLE) && !start) |=> $stable({y0_re, y0_im, y1_re, y1_im}));
endmodule

// File: tb/bfly_butterfly_tb.sv
// Self-checking bench: a vector table compared against a wide-integer reference,
// then directed cases for reset, ties, saturation, hold and restart.
module bfly_butterfly_tb;
    localparam int NV = 8;
    // Packed order: a_re, a_im, b_re, b_im, w_re, w_im.
    localparam logic [95:0] VEC [NV] = '{
        {16'h1000, 16'h2000, 16'h4000, 16'h0000, 16'h7FFF, 16'h0000},
        {16'h0000, 16'h0000, 16'h1234, 16'hFA99, 16'h5A82, 16'hA57E},
        {16'hD000, 16'h1111, 16'hE000, 16'h3000, 16'h0000, 16'h7FFF},
        {16'h0100, 16'hFF00, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h0000},
        {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
        {16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h7FFF},
        {16'h0ABC, 16'hF211, 16'h0003, 16'hFFFD, 16'h4000, 16'h4000},
        {16'h0001, 16'hFFFF, 16'h7000, 16'hA000, 16'hDCBB, 16'h1357}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
    logic done;
    logic signed [15:0] y0_re, y0_im, y1_re, y1_im;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bfly_butterfly u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
        .done(done), .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint rnd(input longint p);
        longint q = p >>> 15;
        longint f = p & 64'sd32767;
        if (f > 16384 || (f == 16384 && q[0])) q = q + 1;
        return q;
    endfunction

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic ref_bfly(input logic [95:0] v, output longint r0r, r0i, r1r, r1i);
        longint ar = longint'($signed(v[95:80]));
        longint ai = longint'($signed(v[79:64]));
        longint br = longint'($signed(v[63:48]));
        longint bi = longint'($signed(v[47:32]));
        longint wr = longint'($signed(v[31:16]));
        longint wi = longint'($signed(v[15:0]));
        longint tr = rnd(br * wr - bi * wi);
        longint ti = rnd(br * wi + bi * wr);
        r0r = sat16(ar + tr); r0i = sat16(ai + ti);
        r1r = sat16(ar - tr); r1i = sat16(ai - ti);
    endtask

    task automatic drive(input logic [95:0] v);
        {a_re, a_im, b_re, b_im, w_re, w_im} = v;
    endtask

    // Pulse start with operands v; returns on the negedge after the sampling edge.
    task automatic pulse_start(input logic [95:0] v);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_ref(input string req, input logic [95:0] v);
        longint e0r, e0i, e1r, e1i;
        ref_bfly(v, e0r, e0i, e1r, e1i);
        check(req, longint'(y0_re), e0r);
        check(req, longint'(y0_im), e0i);
        check(req, longint'(y1_re), e1r);
        check(req, longint'(y1_im), e1i);
    endtask

    task automatic run_and_check(input string req, input logic [95:0] v);
        int lat;
        pulse_start(v);
        wait_done(lat);
        check({req, " latency R5"}, lat, 11);
        check_ref(req, v);
        @(negedge clk);
        check("R5 done single cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state.
        check("R8 done low in reset", longint'(done), 0);
        check("R8 y0_re zero", longint'(y0_re), 0);
        check("R8 y1_im zero", longint'(y1_im), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: table walk against the reference (includes rails, R4, and ties, R3).
        for (int i = 0; i < NV; i++) begin
            run_and_check("R1 vector", VEC[i]);
        end

        // R3: exact ties round to even.
        run_and_check("R3 tie +1.5", {16'h0000, 16'h0000, 16'h0003, 16'h0000, 16'h4000, 16'h0000});
        check("R3 +1.5 -> 2", longint'(y0_re), 2);
        run_and_check("R3 tie -1.5", {16'h0000, 16'h0000, 16'hFFFD, 16'h0000, 16'h4000, 16'h0000});
        check("R3 -1.5 -> -2", longint'(y0_re), -2);
        run_and_check("R3 tie +0.5", {16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h4000, 16'h0000});
        check("R3 +0.5 -> 0", longint'(y0_re), 0);
        check("R3 -0.5 -> 0", longint'(y1_re), 0);

        // R2: non-tie fractions round to the nearer neighbour.
        run_and_check("R2 1.25", {16'h0000, 16'h0000, 16'h0005, 16'h0000, 16'h2000, 16'h0000});
        check("R2 1.25 -> 1", longint'(y0_re), 1);
        run_and_check("R2 1.75", {16'h0000, 16'h0000, 16'h0007, 16'h0000, 16'h2000, 16'h0000});
        check("R2 1.75 -> 2", longint'(y0_re), 2);

        // R4: saturation at both rails.
        run_and_check("R4 pos", {16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000});
        check("R4 sum clamps to 32767", longint'(y0_re), 32767);
        check("R4 diff unclamped", longint'(y1_re), 1);
        run_and_check("R4 neg", {16'h8000, 16'h0000, 16'h8000, 16'h0000, 16'h7FFF, 16'h0000});
        check("R4 sum clamps to -32768", longint'(y0_re), -32768);
        check("R4 diff unclamped", longint'(y1_re), -1);

        // R6: results hold while the inputs wander.
        run_and_check("R6 setup", VEC[7]);
        drive(VEC[3]);
        repeat (15) @(negedge clk);
        check_ref("R6 hold", VEC[7]);
        check("R6 no spurious done", longint'(done), 0);

        // R7: a restart mid-operation takes the new operands.
        begin
            int lat;
            pulse_start(VEC[1]);
            repeat (3) @(negedge clk);
            pulse_start(VEC[2]);
            wait_done(lat);
            check("R7 latency from restart", lat, 11);
            check_ref("R7 new operands", VEC[2]);
        end

        // R8: reset during an operation clears outputs and suppresses done.
        begin
            int seen = 0;
            pulse_start(VEC[4]);
            repeat (3) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            for (int k = 0; k < 15; k++) begin
                @(negedge clk);
                if (done) seen++;
            end
            check("R8 no done after reset", seen, 0);
            check("R8 y0_re cleared", longint'(y0_re), 0);
            check("R8 y1_im cleared", longint'(y1_im), 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule